// File: doc/BRIEF.md
# Packed Lane Compare, Min/Max and Average Unit

This unit is a one-stage packed-integer ALU for 64-bit operand pairs. A request carries the operands, an element size (byte, halfword or word), an operation code and a signedness select. Each lane is handled on its own. The operations are:

- an equality test or a greater-than test, which fill each lane with all ones or all zeros;
- a signed or unsigned minimum or maximum;
- a wrapping sum or difference;
- an unsigned halving average, with or without rounding.

Next to the 64-bit result, the unit returns a 32-bit status word. It holds a negative flag and a zero flag for each result lane. Where these flags sit depends on the element size.

Requests come in on a valid/ready handshake. Results go out on a second valid/ready handshake. The result and the status word are registered together, and only an accepted request changes them. While the output holds an unconsumed result and the consumer stalls, `in_ready` stays low, so back-pressure reaches the producer in the same cycle. When the consumer takes the result, `in_ready` goes high again in that cycle. This lets the unit accept one request per clock when the output is not stalled.

Top module: `lane_cmpmm_alu`

## Requirements
- R1: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. After an acceptance, `out_valid` is high from the next cycle with that request's result. After a handshake with no new acceptance, `out_valid` falls.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_flags` hold their values, and a request offered then is not taken.
- R3: While `rst_n` is low, `out_valid`, `out_data` and `out_flags` are all zero.
- R4: Opcode 0 (equality) sets a lane to all ones when the two operand lanes are equal and to all zeros otherwise. `in_signed` has no effect on it.
- R5: Opcode 1 (greater-than) sets a lane to all ones when the A lane is greater than the B lane and to all zeros otherwise. The comparison is two's-complement when `in_signed` is 1 and unsigned when it is 0.
- R6: Opcode 2 returns the smaller and opcode 3 the larger of the A and B lanes. The comparison is signed or unsigned as chosen by `in_signed`.
- R7: Opcode 4 returns A+B and opcode 5 returns A-B, each modulo the lane width. No carry or borrow passes between lanes.
- R8: Opcode 6 returns (A+B)>>1 and opcode 7 returns (A+B+1)>>1. Both treat the lanes as unsigned and use a sum one bit wider than the lane. At word size both return a zero result and a zero status word.
- R9: `in_size` 0 selects eight byte lanes, 1 selects four halfword lanes, and 2 and 3 both select two word lanes. Lane i occupies bits starting at i times the lane width.
- R10: For lane i, the negative flag sits at status bit 4i+3 (byte), 8i+7 (halfword) or 16i+15 (word). The zero flag sits one bit below the negative flag. Every other status bit is zero.
- R11: A lane's negative flag is the top bit of its result lane, and its zero flag is set when the result lane is zero. Opcodes 6 and 7 leave every negative flag at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The unit can take a request this cycle |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| in_size | input | 2 | Element size: 0 byte, 1 halfword, 2 or 3 word |
| in_op | input | 3 | Operation code, 0 to 7 |
| in_signed | input | 1 | Signed comparison for opcodes 1, 2 and 3 |
| out_valid | output | 1 | A result is held for the consumer |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_data | output | 64 | Packed result |
| out_flags | output | 32 | Per-lane negative and zero flags |

## Verification
Each result and its status word appear on the outputs in the cycle after the edge that accepted the request, and they stay there through any stall. `in_ready` is combinational and follows `out_ready` within the same cycle. The bench model updates its expected valid, data and flag state on the same rising edge at which the unit registers. It compares every output on each falling edge, so every check falls midway between the edge that produced a value and the next one. `out_ready` and `in_valid` are changed at random, which causes stalls and idle gaps while the comparison stays the same on each clock.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

  typedef enum logic [2:0] {
    OP_EQ   = 3'd0,
    OP_GT   = 3'd1,
    OP_MIN  = 3'd2,
    OP_MAX  = 3'd3,
    OP_ADD  = 3'd4,
    OP_SUB  = 3'd5,
    OP_AVG  = 3'd6,
    OP_AVGR = 3'd7
  } lcm_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } lcm_size_e;

endpackage

// File: rtl/lcm_lane.sv
module lcm_lane
  import lcm_pkg::*;
#(
  parameter int W      = 8,
  parameter bit AVG_OK = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lcm_op_e      op,
  input  logic         sgn,
  output logic [W-1:0] r
);

  logic         a_gt_b;
  logic         a_lt_b;
  logic         rnd;
  logic [W:0]   sum_w;

  assign a_gt_b = sgn ? ($signed(a) > $signed(b)) : (a > b);
  assign a_lt_b = sgn ? ($signed(a) < $signed(b)) : (a < b);
  assign rnd    = (op == OP_AVGR);
  assign sum_w  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, rnd};

  always_comb begin
    case (op)
      OP_EQ:   r = (a == b) ? {W{1'b1}} : '0;
      OP_GT:   r = a_gt_b ? {W{1'b1}} : '0;
      OP_MIN:  r = a_lt_b ? a : b;
      OP_MAX:  r = a_gt_b ? a : b;
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      default: r = AVG_OK ? sum_w[W:1] : '0;
    endcase
  end

  // Lane-level checks on the compare, select and average outputs.
  always_comb begin
    if (op == OP_EQ || op == OP_GT) begin
      assert_lanemask_R4: assert (r == '0 || r == {W{1'b1}});
    end
    if (op == OP_MIN || op == OP_MAX) begin
      assert_pick_operand_R6: assert (r == a || r == b);
    end
    if (AVG_OK && (op == OP_AVG || op == OP_AVGR)) begin
      assert_avg_between_R8: assert ((r >= a || r >= b) && (r <= a || r <= b));
    end
  end

endmodule

// File: rtl/lcm_size_slice.sv
module lcm_size_slice
  import lcm_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter bit AVG_OK = 1'b1
) (
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  lcm_op_e             op,
  input  logic                sgn,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W/2-1:0] flags
);

  localparam int NLANE = DATA_W / LANE_W;
  localparam int GRP   = (DATA_W / 2) / NLANE;

  logic is_avg;
  logic z_en;

  assign is_avg = (op == OP_AVG) || (op == OP_AVGR);
  assign z_en   = AVG_OK || !is_avg;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] r;

    lcm_lane #(
      .W      (LANE_W),
      .AVG_OK (AVG_OK)
    ) u_lane (
      .a   (a[i*LANE_W +: LANE_W]),
      .b   (b[i*LANE_W +: LANE_W]),
      .op  (op),
      .sgn (sgn),
      .r   (r)
    );

    assign res[i*LANE_W +: LANE_W] = r;

    if (GRP > 2) begin : g_pad
      assign flags[i*GRP +: GRP-2] = '0;
    end
    assign flags[i*GRP + GRP - 1] = r[LANE_W-1] & ~is_avg;
    assign flags[i*GRP + GRP - 2] = (r == '0) & z_en;
  end

endmodule

// File: rtl/lane_cmpmm_alu.sv
module lane_cmpmm_alu
  import lcm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  input  logic [1:0]  in_size,
  input  logic [2:0]  in_op,
  input  logic        in_signed,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic [31:0] out_flags
);

  localparam int DATA_W = 64;
  localparam int STAT_W = DATA_W / 2;

  lcm_op_e           op_e;
  logic [DATA_W-1:0] res_b, res_h, res_w, res_sel;
  logic [STAT_W-1:0] flg_b, flg_h, flg_w, flg_sel;
  logic              take;

  assign op_e = lcm_op_e'(in_op);

  lcm_size_slice #(.DATA_W(DATA_W), .LANE_W(DATA_W/8), .AVG_OK(1'b1)) u_byte (
    .a(in_a), .b(in_b), .op(op_e), .sgn(in_signed), .res(res_b), .flags(flg_b));
  lcm_size_slice #(.DATA_W(DATA_W), .LANE_W(DATA_W/4), .AVG_OK(1'b1)) u_half (
    .a(in_a), .b(in_b), .op(op_e), .sgn(in_signed), .res(res_h), .flags(flg_h));
  lcm_size_slice #(.DATA_W(DATA_W), .LANE_W(DATA_W/2), .AVG_OK(1'b0)) u_word (
    .a(in_a), .b(in_b), .op(op_e), .sgn(in_signed), .res(res_w), .flags(flg_w));

  always_comb begin
    case (lcm_size_e'(in_size))
      SZ_BYTE: begin res_sel = res_b; flg_sel = flg_b; end
      SZ_HALF: begin res_sel = res_h; flg_sel = flg_h; end
      default: begin res_sel = res_w; flg_sel = flg_w; end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= res_sel;
      out_flags <= flg_sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flags));

  assert_drain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: tb/test_lane_cmpmm_alu.sv
module test_lane_cmpmm_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [63:0] in_a, in_b;
  logic [1:0]  in_size;
  logic [2:0]  in_op;
  logic        in_signed;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] out_data;
  logic [31:0] out_flags;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lane_cmpmm_alu i_lane_cmpmm_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_size(in_size), .in_op(in_op),
    .in_signed(in_signed), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_flags(out_flags));

  // Behavioural reference: integer arithmetic per lane.
  function automatic logic [95:0] ref_calc(input logic [63:0] a, input logic [63:0] b,
                                           input int sz, input int op, input bit sgn);
    int L, n, g;
    logic [63:0] res;
    logic [31:0] fl;
    L = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    n = 64 / L;
    g = 32 / n;
    res = '0;
    fl = '0;
    if (op >= 6 && L == 32) return '0;
    for (int i = 0; i < n; i++) begin
      longint unsigned m, ua, ub, ur;
      longint sa, sb;
      bit gt, lt;
      m  = (64'd1 << L) - 1;
      ua = (a >> (i * L)) & m;
      ub = (b >> (i * L)) & m;
      sa = ((ua >> (L - 1)) & 1) != 0 ? longint'(ua) - longint'(m) - 1 : longint'(ua);
      sb = ((ub >> (L - 1)) & 1) != 0 ? longint'(ub) - longint'(m) - 1 : longint'(ub);
      gt = sgn ? (sa > sb) : (ua > ub);
      lt = sgn ? (sa < sb) : (ua < ub);
      case (op)
        0: ur = (ua == ub) ? m : 0;
        1: ur = gt ? m : 0;
        2: ur = lt ? ua : ub;
        3: ur = gt ? ua : ub;
        4: ur = (ua + ub) & m;
        5: ur = (ua - ub) & m;
        6: ur = (ua + ub) >> 1;
        default: ur = (ua + ub + 1) >> 1;
      endcase
      res = res | (64'(ur) << (i * L));
      if (op < 6 && ((ur >> (L - 1)) & 1) != 0) fl[g*i + g - 1] = 1'b1;
      if (ur == 0) fl[g*i + g - 2] = 1'b1;
    end
    return {fl, res};
  endfunction

  function automatic string op_tag(input int op, input int sz);
    string t;
    case (op)
      0: t = "R4";
      1: t = "R5";
      2, 3: t = "R6";
      4, 5: t = "R7";
      default: t = "R8";
    endcase
    if (sz == 3) t = {t, " R9"};
    return t;
  endfunction

  // Cycle model, updated on the same edge as the unit.
  logic        m_valid;
  logic [63:0] m_data;
  logic [31:0] m_flags;
  bit          m_took;
  string       m_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_flags <= '0;
      m_took  <= 1'b0;
      m_tag   <= "R3";
    end else if (in_valid && (!m_valid || out_ready)) begin
      logic [95:0] e;
      e = ref_calc(in_a, in_b, int'(in_size), int'(in_op), in_signed);
      m_valid <= 1'b1;
      m_data  <= e[63:0];
      m_flags <= e[95:64];
      m_took  <= 1'b1;
      m_tag   <= op_tag(int'(in_op), int'(in_size));
    end else begin
      m_took <= 1'b0;
      if (out_ready) m_valid <= 1'b0;
      else if (m_valid) m_tag <= "R2";
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(in_ready == (!m_valid || out_ready), "R1 in_ready", 64'(in_ready), 64'(!m_valid || out_ready));
    chk(out_valid == m_valid, "R1 out_valid", 64'(out_valid), 64'(m_valid));
    chk(out_data == m_data, {m_tag, " data"}, out_data, m_data);
    chk(out_flags == m_flags, {m_tag, " R10 R11 flags"}, 64'(out_flags), 64'(m_flags));
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    out_ready = ($urandom % 4) != 0;
  endtask

  function automatic logic [63:0] pat(input int k);
    case (k)
      0: return 64'h0000_0000_0000_0000;
      1: return 64'h807F_807F_807F_807F;
      2: return 64'h7F80_7F80_7F80_7F80;
      3: return 64'h8000_0000_7FFF_8000;
      4: return 64'h8000_0000_8000_0000;
      5: return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return 64'h0001_0001_0001_0001;
    endcase
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    in_size = '0; in_op = '0; in_signed = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(out_valid == 1'b0, "R3 out_valid", 64'(out_valid), 64'd0);
    chk(out_data == '0, "R3 out_data", out_data, 64'd0);
    chk(out_flags == '0, "R3 out_flags", 64'(out_flags), 64'd0);
    rst_n = 1'b1;
    step();
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 8; op++) begin
        for (int sg = 0; sg < 2; sg++) begin
          for (int p = 0; p < 10; p++) begin
            if (($urandom % 5) == 0) begin
              in_valid = 1'b0;
              step();
            end
            if (p < 7) begin
              in_a = pat(p);
              in_b = pat((p * 3 + 1) % 7);
            end else if (p == 7) begin
              in_a = {$urandom, $urandom};
              in_b = in_a;
            end else begin
              in_a = {$urandom, $urandom};
              in_b = {$urandom, $urandom};
            end
            in_size = 2'(sz);
            in_op = 3'(op);
            in_signed = sg[0];
            in_valid = 1'b1;
            step();
            while (!m_took) step();
          end
        end
      end
    end
    in_valid = 1'b0;
    repeat (6) begin
      @(negedge clk);
      compare_all();
      out_ready = 1'b1;
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule